// File: doc/BRIEF.md
# BCD Reloading Divider with Toggle Output

This block is a two-digit packed-BCD down counter with a synchronous parallel load and a toggle output stage. Its main use is as a programmable frequency divider. The active-low zero flag is wired back to the load-enable input. With that loop in place, a load value N gives a count cycle of N+1 steps. The output flip-flop changes state once per cycle, so it produces a 50% duty square wave at 1/(2(N+1)) of the step rate. This is suitable as the alternating drive signal for a liquid-crystal panel.

Everything runs on one system clock. Counting advances on a step event. The event is either a rising transition on one tick input or a falling transition on a complementary tick input, and a select input picks which one. Both tick inputs are sampled by the system clock. Two asynchronous active-low inputs force the output flip-flop low or high.

Top module: `bcd_reload_divider`

## Requirements
- R1: The count is packed BCD: bits 3:0 hold the units digit and bits 7:4 the tens digit. Every nibble of a loaded value must be 0 to 9, so the largest load is 99.
- R2: On a step event with `presetEn` high, the count drops by one in BCD. A units digit of 0 becomes 9 and borrows from the tens digit, and 00 wraps to 99.
- R3: On a step event with `presetEn` low, the count takes `loadVal`. Loading has priority over counting.
- R4: With `edgeSel` = 0, a step event is a 0-to-1 change of `tickRise` between two clock samples. With `edgeSel` = 1, it is a 1-to-0 change of `tickFall`. The unselected tick input is ignored. Without an event the count holds.
- R5: `zeroN` is low exactly while the count is 00.
- R6: With `zeroN` fed back to `presetEn` and a load of N, the count runs N, N-1, …, 0 and repeats, so `zeroN` is low on one step in every N+1. A load of 0 keeps `zeroN` low for good.
- R7: With `setN` and `clrN` both high, `divOut` inverts on the clock edge after each rising edge of `zeroN`.
- R8: `clrN` low with `setN` high forces `divOut` low at once, and `setN` low with `clrN` high forces it high. With both low, neither input forces the output. `rstN` low forces `divOut` low.
- R9: Reset clears the count to 00, so with the feedback connected, the first step event loads the preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadVal | input | 8 | Packed BCD preset value |
| presetEn | input | 1 | High counts down, low loads `loadVal` on a step event |
| edgeSel | input | 1 | 0 selects rising `tickRise`, 1 selects falling `tickFall` |
| tickRise | input | 1 | Step source counted on its rising transition |
| tickFall | input | 1 | Step source counted on its falling transition |
| setN | input | 1 | Asynchronous active-low force of `divOut` high |
| clrN | input | 1 | Asynchronous active-low force of `divOut` low |
| zeroN | output | 1 | Low while the count is 00 |
| divOut | output | 1 | Toggled divider output |

## Verification
The counter is exercised with loads that need no borrow (05), one that needs a tens borrow (10), and a count down from 00 that needs the 00-to-99 wrap. Because `zeroN` is the only view of the count, the number of steps to reach zero separates a correct digit borrow from a wrong one. Feedback runs with loads of 3, 32 and 0 check the N+1 period, the toggle phase of `divOut`, and the degenerate zero load. Each tick input is pulsed while the other one is selected, which shows that the selection really excludes it. A set/clear sequence that passes through the both-low state separates a forcing input that respects the other one from one that overrides it.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  typedef struct packed {
    logic step;
    logic load;
  } ctrlStrb_t;
endpackage

// File: rtl/bcd_div_ctrl.sv
module bcd_div_ctrl
  import bcd_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      edgeSel,
  input  logic      tickRise,
  input  logic      tickFall,
  input  logic      presetEn,
  output ctrlStrb_t strb
);
  logic riseQ;
  logic fallQ;
  logic tickEvt;

  // previous samples of the tick inputs, reset to their idle levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= 1'b0;
      fallQ <= 1'b1;
    end else begin
      riseQ <= tickRise;
      fallQ <= tickFall;
    end
  end

  assign tickEvt   = edgeSel ? (fallQ & ~tickFall) : (~riseQ & tickRise);
  assign strb.step = tickEvt & presetEn;
  assign strb.load = tickEvt & ~presetEn;
endmodule

// File: rtl/bcd_div_dp.sv
module bcd_div_dp
  import bcd_div_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrb_t    strb,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] countQ
);
  logic [W-1:0]      countDec;
  logic [DIGITS-1:0] borrow;

  assign borrow[0] = 1'b1;

  // one BCD digit per iteration, borrow rippling upward
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    assign dig = countQ[4*g +: 4];
    assign countDec[4*g +: 4] = !borrow[g] ? dig :
                                (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] & (dig == 4'd0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          countQ <= '0;
    else if (strb.load) countQ <= loadVal;
    else if (strb.step) countQ <= countDec;
  end
endmodule

// File: rtl/bcd_div_toggle.sv
module bcd_div_toggle (
  input  logic clk,
  input  logic rstN,
  input  logic setN,
  input  logic clrN,
  input  logic zeroN,
  output logic divOut
);
  logic zeroDly;
  logic forceLo;
  logic forceHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zeroDly <= 1'b0;
    else       zeroDly <= zeroN;
  end

  // a force input acts only while the opposite one is released
  assign forceLo = ~rstN | (~clrN & setN);
  assign forceHi = rstN & ~setN & clrN;

  always_ff @(posedge clk or posedge forceLo or posedge forceHi) begin
    if (forceLo)                divOut <= 1'b0;
    else if (forceHi)           divOut <= 1'b1;
    else if (zeroN && !zeroDly) divOut <= ~divOut;
  end
endmodule

// File: rtl/bcd_reload_divider.sv
module bcd_reload_divider
  import bcd_div_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] loadVal,
  input  logic         presetEn,
  input  logic         edgeSel,
  input  logic         tickRise,
  input  logic         tickFall,
  input  logic         setN,
  input  logic         clrN,
  output logic         zeroN,
  output logic         divOut
);
  ctrlStrb_t    strb;
  logic [W-1:0] countQ;

  bcd_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .edgeSel(edgeSel), .tickRise(tickRise),
    .tickFall(tickFall), .presetEn(presetEn), .strb(strb)
  );

  bcd_div_dp #(.DIGITS(DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .countQ(countQ)
  );

  assign zeroN = |countQ;

  bcd_div_toggle u_tgl (
    .clk(clk), .rstN(rstN), .setN(setN), .clrN(clrN),
    .zeroN(zeroN), .divOut(divOut)
  );
endmodule

// File: rtl/bcd_div_chk.sv
module bcd_div_chk
  import bcd_div_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rstN,
  input ctrlStrb_t    strb,
  input logic [W-1:0] loadVal,
  input logic [W-1:0] countQ,
  input logic         setN,
  input logic         clrN,
  input logic         zeroN,
  input logic         divOut
);
  function automatic logic isBcd(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_LOAD_IS_BCD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> isBcd(loadVal)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> countQ == $past(loadVal)); // R3

  AST_UNITS_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && countQ[3:0] != 4'd0) |=> countQ[3:0] == $past(countQ[3:0]) - 4'd1); // R2

  AST_UNITS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && countQ[3:0] == 4'd0) |=> countQ[3:0] == 4'd9); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> $stable(countQ)); // R4

  AST_TOGGLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (setN && clrN && $past(setN && clrN) && $past($rose(zeroN))) |-> divOut != $past(divOut)); // R7

  AST_CLR_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (!clrN && setN) |-> !divOut); // R8

  AST_SET_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (!setN && clrN) |-> divOut); // R8
endmodule

bind bcd_reload_divider bcd_div_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .countQ(countQ),
  .setN(setN), .clrN(clrN), .zeroN(zeroN), .divOut(divOut)
);

// File: tb/sim_bcd_reload_divider.sv
`timescale 1ns/1ps
module sim_bcd_reload_divider;
  logic clk = 1'b0;
  logic rstN, edgeSel, tickRise, tickFall, setN, clrN;
  logic presetDrv, fbOn;
  logic [7:0] loadVal;
  logic presetEn, zeroN, divOut;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign presetEn = fbOn ? zeroN : presetDrv;

  bcd_reload_divider u0 (
    .clk(clk), .rstN(rstN), .loadVal(loadVal), .presetEn(presetEn),
    .edgeSel(edgeSel), .tickRise(tickRise), .tickFall(tickFall),
    .setN(setN), .clrN(clrN), .zeroN(zeroN), .divOut(divOut)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fbOn = 1'b0; presetDrv = 1'b1; edgeSel = 1'b0;
    tickRise = 1'b0; tickFall = 1'b1; setN = 1'b1; clrN = 1'b1;
    loadVal = 8'h00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one tick pulse on the given input; returns after the toggle stage settled
  task automatic pulse(bit onFall);
    @(negedge clk);
    if (onFall) tickFall = 1'b0; else tickRise = 1'b1;
    @(negedge clk);
    if (onFall) tickFall = 1'b1; else tickRise = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) pulse(edgeSel);
  endtask

  task automatic loadNow(logic [7:0] v);
    loadVal = v; presetDrv = 1'b0;
    pulse(edgeSel);
    presetDrv = 1'b1;
  endtask

  task automatic tResetState();
    doReset(); #1;
    chk("R9 count zero after reset", zeroN, 1'b0);
    chk("R8 divOut low after reset", divOut, 1'b0);
  endtask

  task automatic tPlainCount();
    doReset();
    loadNow(8'h05);
    chk("R3 load 05 leaves zero", zeroN, 1'b1);
    steps(4);
    chk("R5 count 01 not zero", zeroN, 1'b1);
    steps(1);
    chk("R2 five steps reach 00", zeroN, 1'b0);
  endtask

  task automatic tBorrow();
    doReset();
    loadNow(8'h10);
    steps(9);
    chk("R2 tens borrow count 01", zeroN, 1'b1);
    steps(1);
    chk("R2 tens borrow reaches 00", zeroN, 1'b0);
  endtask

  task automatic tWrap();
    doReset();
    steps(1);
    chk("R2 00 wraps to 99", zeroN, 1'b1);
    steps(98);
    chk("R2 99 minus 98 is 01", zeroN, 1'b1);
    steps(1);
    chk("R2 99 steps back to 00", zeroN, 1'b0);
  endtask

  task automatic tEdgeSel();
    doReset();
    edgeSel = 1'b1;
    loadNow(8'h01);
    chk("R4 falling tick loads", zeroN, 1'b1);
    pulse(1'b0);
    chk("R4 rise ignored when fall selected", zeroN, 1'b1);
    repeat (5) @(negedge clk);
    #1 chk("R4 count holds without event", zeroN, 1'b1);
    pulse(1'b1);
    chk("R4 falling tick counts", zeroN, 1'b0);
    edgeSel = 1'b0;
    pulse(1'b1);
    chk("R4 fall ignored when rise selected", zeroN, 1'b0);
    pulse(1'b0);
    chk("R4 rising tick counts", zeroN, 1'b1);
  endtask

  task automatic tReload(logic [7:0] bcdVal, int n, int periods);
    logic expDiv;
    doReset();
    loadVal = bcdVal; fbOn = 1'b1; expDiv = 1'b0;
    for (int k = 1; k <= periods * (n + 1); k++) begin
      pulse(1'b0);
      if (n > 0 && (k % (n + 1)) == 1) expDiv = ~expDiv;
      chk("R6 zero flag once per N+1", zeroN, (k % (n + 1)) != 0);
      chk("R7 divOut toggles per cycle", divOut, expDiv);
    end
    fbOn = 1'b0;
  endtask

  task automatic tForce();
    doReset();
    @(negedge clk); setN = 1'b0; #1;
    chk("R8 setN forces high", divOut, 1'b1);
    @(negedge clk); clrN = 1'b0; #1;
    chk("R8 both low does not clear", divOut, 1'b1);
    @(negedge clk); setN = 1'b1; #1;
    chk("R8 clrN forces low", divOut, 1'b0);
    @(negedge clk); setN = 1'b0; #1;
    chk("R8 both low does not set", divOut, 1'b0);
    @(negedge clk); setN = 1'b1; clrN = 1'b1; #1;
    chk("R8 release keeps value", divOut, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tResetState();
    tPlainCount();
    tBorrow();
    tWrap();
    tEdgeSel();
    tReload(8'h03, 3, 3);
    tReload(8'h32, 32, 2);
    tReload(8'h00, 0, 4);
    tForce();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule